// File: doc/BRIEF.md
# Decimal Adjust Unit

This block corrects an 8-bit accumulator after a binary add or subtract has been applied to binary-coded decimal operands. It takes the low accumulator byte, the high accumulator byte, and the carry and half-carry flags that the preceding arithmetic produced. It then applies one of four corrections, chosen by a two-bit operation code.

There are two kinds of correction. The packed kind repairs both decimal digits held in the low byte and leaves the high byte alone. It also produces sign, zero and parity flags from the corrected byte. The unpacked kind repairs a single digit in the low byte, clears that byte's upper nibble, and steps the high byte by one when a correction takes place.

A request is presented with `op_valid` high for one clock. The corrected values are registered on that edge. They appear with `res_valid` high during the following cycle, and they are then held until the next request.

The sequencing uses a two-state machine:
- ST_IDLE means no fresh result is present.
- ST_SHOW means the outputs were loaded on the last edge.

There are two transitions:
- The load transition is taken on any cycle with `op_valid` high, from either state, into ST_SHOW.
- The drop transition is taken on any cycle with `op_valid` low, from either state, into ST_IDLE.

Top module: `dadj_unit`

## Requirements
- R1: `op_sel` encodes the operation: 0 = packed add, 1 = packed subtract, 2 = unpacked add, 3 = unpacked subtract. In a packed operation, when `af_in` is 1 or `al_in[3:0]` is above 9, the byte gets +6 (add) or −6 (subtract) and `af_q` becomes 1.
- R2: In a packed operation, when `cf_in` is 1 or the byte left by the R1 step is above 0x9F, the byte gets +0x60 (add) or −0x60 (subtract) and `cf_q` becomes 1. The threshold is tested on the byte after the R1 step, not on `al_in`.
- R3: A packed operation never clears a flag: `af_in`=1 gives `af_q`=1, and `cf_in`=1 gives `cf_q`=1. When neither correction condition holds, the byte and both flags pass through unchanged.
- R4: After a packed operation, `sf_q` is bit 7 of the final byte, `zf_q` is 1 when the final byte is 0, and `pf_q` is 1 when the final byte has an even number of 1 bits.
- R5: In an unpacked operation, when `af_in` is 1 or `al_in[3:0]` is above 9, the byte gets +6 or −6, `ah_q` is `ah_in` +1 (add) or −1 (subtract), and `af_q` and `cf_q` are both 1.
- R6: In an unpacked operation with neither condition of R5 true, `af_q` and `cf_q` are both 0 (even if `cf_in` was 1), and `ah_q` equals `ah_in`.
- R7: An unpacked operation always leaves `al_q[7:4]` at 0. Only the low nibble of the adjusted byte is kept.
- R8: An unpacked operation leaves `sf_q`, `zf_q` and `pf_q` at the values they held before it.
- R9: All byte arithmetic wraps modulo 256: 0x00 − 6 gives 0xFA, and 0xFA + 6 gives 0x00.
- R10: The results of a request appear on the clock edge where `op_valid` is sampled high. `res_valid` is 1 for exactly the following cycle. While `op_valid` is low, every result output holds.
- R11: A packed operation sets `ah_q` to `ah_in` unchanged.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request strobe, one request per high cycle |
| op_sel | input | 2 | Operation code (see R1) |
| al_in | input | 8 | Low accumulator byte to adjust |
| ah_in | input | 8 | High accumulator byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming half-carry flag |
| res_valid | output | 1 | Result loaded on the previous edge |
| al_q | output | 8 | Adjusted low byte |
| ah_q | output | 8 | Adjusted high byte |
| cf_q | output | 1 | Resulting carry flag |
| af_q | output | 1 | Resulting half-carry flag |
| sf_q | output | 1 | Sign of the packed result |
| zf_q | output | 1 | Zero flag of the packed result |
| pf_q | output | 1 | Even-parity flag of the packed result |

## Verification
The sharpest packed case is 0x9A after an add. The first step carries it to 0xA0, and only then does it cross 0x9F. A design that tested the threshold on the incoming byte would return 0xA0 with carry 0 instead of 0x00 with carry 1.

The bench enters packed operations with both flags already set and no nibble condition. A design that recomputed the flags would drop them there. It also drives subtractions from 0x00, where a design without modulo-256 wrapping gives wrong bytes.

For the unpacked forms, the bench sends a low nibble below 10 together with `cf_in`=1. A design that kept the carry would leave `cf_q` at 1. It also sends a high nibble that must be masked off, and it follows a packed result that sets sign and parity with an unpacked request. A design that recomputed sign, zero and parity there would change them.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    localparam int unsigned DADJ_DW  = 8;
    localparam int unsigned DADJ_NIB = 4;

    typedef enum logic [1:0] {
        OP_PK_ADD = 2'd0,
        OP_PK_SUB = 2'd1,
        OP_UP_ADD = 2'd2,
        OP_UP_SUB = 2'd3
    } dadj_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } dadj_state_e;

    typedef struct packed {
        logic [DADJ_DW-1:0] lo;
        logic [DADJ_DW-1:0] hi;
        logic               cf;
        logic               af;
    } dadj_res_t;

endpackage

// File: rtl/dadj_packed.sv
module dadj_packed #(
    parameter int unsigned DW  = dadj_pkg::DADJ_DW,
    parameter int unsigned NIB = dadj_pkg::DADJ_NIB
) (
    input  logic          sub_mode,
    input  logic [DW-1:0] lo_in,
    input  logic          cf_in,
    input  logic          af_in,
    output logic [DW-1:0] lo_out,
    output logic          cf_out,
    output logic          af_out
);
    // Decimal digit limits and corrections, derived from the nibble width
    localparam logic [NIB-1:0] DIG_MAX  = NIB'(9);
    localparam logic [DW-1:0]  LO_STEP  = DW'(6);
    localparam logic [DW-1:0]  HI_STEP  = DW'(6) << NIB;
    localparam logic [DW-1:0]  HI_LIMIT = (DW'(10) << NIB) - DW'(1);

    logic          lo_fix;
    logic          hi_fix;
    logic [DW-1:0] stage1;

    always_comb begin
        lo_fix = af_in || (lo_in[NIB-1:0] > DIG_MAX);
        if (lo_fix) begin
            stage1 = sub_mode ? (lo_in - LO_STEP) : (lo_in + LO_STEP);
        end else begin
            stage1 = lo_in;
        end
        // second test looks at the byte after the first correction
        hi_fix = cf_in || (stage1 > HI_LIMIT);
        if (hi_fix) begin
            lo_out = sub_mode ? (stage1 - HI_STEP) : (stage1 + HI_STEP);
        end else begin
            lo_out = stage1;
        end
        af_out = af_in | lo_fix;
        cf_out = cf_in | hi_fix;
    end

endmodule

// File: rtl/dadj_unpacked.sv
module dadj_unpacked #(
    parameter int unsigned DW  = dadj_pkg::DADJ_DW,
    parameter int unsigned NIB = dadj_pkg::DADJ_NIB
) (
    input  logic          sub_mode,
    input  logic [DW-1:0] lo_in,
    input  logic [DW-1:0] hi_in,
    input  logic          af_in,
    output logic [DW-1:0] lo_out,
    output logic [DW-1:0] hi_out,
    output logic          fix_out
);
    localparam logic [NIB-1:0] DIG_MAX = NIB'(9);
    localparam logic [DW-1:0]  LO_STEP = DW'(6);
    localparam logic [DW-1:0]  ONE     = DW'(1);

    logic [DW-1:0] stage1;

    always_comb begin
        fix_out = af_in || (lo_in[NIB-1:0] > DIG_MAX);
        if (fix_out) begin
            stage1 = sub_mode ? (lo_in - LO_STEP) : (lo_in + LO_STEP);
            hi_out = sub_mode ? (hi_in - ONE) : (hi_in + ONE);
        end else begin
            stage1 = lo_in;
            hi_out = hi_in;
        end
        lo_out = {{(DW-NIB){1'b0}}, stage1[NIB-1:0]};
    end

endmodule

// File: rtl/dadj_szp.sv
module dadj_szp #(
    parameter int unsigned DW = dadj_pkg::DADJ_DW
) (
    input  logic [DW-1:0] val,
    output logic          sign,
    output logic          zero,
    output logic          even
);
    always_comb begin
        sign = val[DW-1];
        zero = (val == '0);
        even = ~(^val);
    end

endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
#(
    parameter int unsigned DW  = DADJ_DW,
    parameter int unsigned NIB = DADJ_NIB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_sel,
    input  logic [DW-1:0] al_in,
    input  logic [DW-1:0] ah_in,
    input  logic          cf_in,
    input  logic          af_in,
    output logic          res_valid,
    output logic [DW-1:0] al_q,
    output logic [DW-1:0] ah_q,
    output logic          cf_q,
    output logic          af_q,
    output logic          sf_q,
    output logic          zf_q,
    output logic          pf_q
);
    dadj_state_e   st_q;
    dadj_state_e   st_d;
    dadj_op_e      op;

    logic [DW-1:0] pk_lo;
    logic          pk_cf;
    logic          pk_af;
    logic          pk_sign;
    logic          pk_zero;
    logic          pk_even;
    logic [DW-1:0] up_lo;
    logic [DW-1:0] up_hi;
    logic          up_fix;
    dadj_res_t     nxt;

    assign op = dadj_op_e'(op_sel);

    dadj_packed #(.DW(DW), .NIB(NIB)) u_pk (
        .sub_mode (op_sel[0]),
        .lo_in    (al_in),
        .cf_in    (cf_in),
        .af_in    (af_in),
        .lo_out   (pk_lo),
        .cf_out   (pk_cf),
        .af_out   (pk_af)
    );

    dadj_unpacked #(.DW(DW), .NIB(NIB)) u_up (
        .sub_mode (op_sel[0]),
        .lo_in    (al_in),
        .hi_in    (ah_in),
        .af_in    (af_in),
        .lo_out   (up_lo),
        .hi_out   (up_hi),
        .fix_out  (up_fix)
    );

    dadj_szp #(.DW(DW)) u_szp (
        .val  (pk_lo),
        .sign (pk_sign),
        .zero (pk_zero),
        .even (pk_even)
    );

    // Next-state logic: load on a request, drop otherwise
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = op_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: st_d = op_valid ? ST_SHOW : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Result selection by operation
    always_comb begin
        unique case (op)
            OP_PK_ADD, OP_PK_SUB: begin
                nxt.lo = pk_lo;
                nxt.hi = ah_in;
                nxt.cf = pk_cf;
                nxt.af = pk_af;
            end
            OP_UP_ADD, OP_UP_SUB: begin
                nxt.lo = up_lo;
                nxt.hi = up_hi;
                nxt.cf = up_fix;
                nxt.af = up_fix;
            end
            default: begin
                nxt.lo = al_in;
                nxt.hi = ah_in;
                nxt.cf = cf_in;
                nxt.af = af_in;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '0;
            ah_q <= '0;
            cf_q <= 1'b0;
            af_q <= 1'b0;
            sf_q <= 1'b0;
            zf_q <= 1'b0;
            pf_q <= 1'b0;
        end else if (op_valid) begin
            al_q <= nxt.lo;
            ah_q <= nxt.hi;
            cf_q <= nxt.cf;
            af_q <= nxt.af;
            if (!op_sel[1]) begin
                sf_q <= pk_sign;
                zf_q <= pk_zero;
                pf_q <= pk_even;
            end
        end
    end

    assign res_valid = (st_q == ST_SHOW);

endmodule

// File: rtl/dadj_chk.sv
module dadj_chk #(
    parameter int unsigned DW = dadj_pkg::DADJ_DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [1:0]    op_sel,
    input logic [DW-1:0] al_in,
    input logic [DW-1:0] ah_in,
    input logic          cf_in,
    input logic          af_in,
    input logic          res_valid,
    input logic [DW-1:0] al_q,
    input logic [DW-1:0] ah_q,
    input logic          cf_q,
    input logic          af_q,
    input logic          sf_q,
    input logic          zf_q,
    input logic          pf_q
);
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(al_q) && $stable(ah_q) && $stable(cf_q) && $stable(af_q)));

    p_sticky_af_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_sel[1] && af_in) |=> af_q);

    p_sticky_cf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_sel[1] && cf_in) |=> cf_q);

    p_pk_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_sel[1]) |=> (ah_q == $past(ah_in)));

    p_up_flags_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel[1]) |=> (af_q == cf_q));

    p_up_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel[1]) |=> (al_q[DW-1:DW/2] == '0));

    p_up_keep_szp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel[1]) |=> ($stable(sf_q) && $stable(zf_q) && $stable(pf_q)));

    p_pk_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_sel[1]) |=> (zf_q == (al_q == '0)));

endmodule

bind dadj_unit dadj_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_dadj_unit.sv
`timescale 1ns/1ps
module sim_dadj_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [7:0] al_in = 8'h00;
    logic [7:0] ah_in = 8'h00;
    logic       cf_in = 1'b0;
    logic       af_in = 1'b0;
    logic       res_valid;
    logic [7:0] al_q;
    logic [7:0] ah_q;
    logic       cf_q;
    logic       af_q;
    logic       sf_q;
    logic       zf_q;
    logic       pf_q;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dadj_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .al_in(al_in), .ah_in(ah_in), .cf_in(cf_in), .af_in(af_in),
        .res_valid(res_valid), .al_q(al_q), .ah_q(ah_q), .cf_q(cf_q),
        .af_q(af_q), .sf_q(sf_q), .zf_q(zf_q), .pf_q(pf_q)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Present one request, then sample at the falling edge after the load edge
    task automatic issue(input logic [1:0] sel, input logic [7:0] al, input logic [7:0] ah,
                         input logic cf, input logic af);
        @(negedge clk);
        op_sel = sel; al_in = al; ah_in = ah; cf_in = cf; af_in = af; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic [7:0] al, input logic [7:0] ah,
                              input logic cf, input logic af);
        chk({tag, " al"}, al_q, al);
        chk({tag, " ah"}, ah_q, ah);
        chk({tag, " cf"}, 8'(cf_q), 8'(cf));
        chk({tag, " af"}, 8'(af_q), 8'(af));
    endtask

    task automatic expect_szp(input string tag, input logic s, input logic z, input logic p);
        chk({tag, " sf"}, 8'(sf_q), 8'(s));
        chk({tag, " zf"}, 8'(zf_q), 8'(z));
        chk({tag, " pf"}, 8'(pf_q), 8'(p));
    endtask

    task automatic t_reset_r12();
        expect_res("R12 reset", 8'h00, 8'h00, 1'b0, 1'b0);
        expect_szp("R12 reset", 1'b0, 1'b0, 1'b0);
        chk("R12 reset valid", 8'(res_valid), 8'h00);
    endtask

    task automatic t_packed_add();
        issue(2'd0, 8'h15, 8'h44, 1'b0, 1'b0);
        expect_res("R3 passthru", 8'h15, 8'h44, 1'b0, 1'b0);
        expect_szp("R4 0x15", 1'b0, 1'b0, 1'b0);
        issue(2'd0, 8'h9A, 8'h21, 1'b0, 1'b0);
        expect_res("R2 post-step threshold", 8'h00, 8'h21, 1'b1, 1'b1);
        expect_szp("R4 zero", 1'b0, 1'b1, 1'b1);
        issue(2'd0, 8'h0C, 8'h00, 1'b0, 1'b0);
        expect_res("R1 low nibble", 8'h12, 8'h00, 1'b0, 1'b1);
        issue(2'd0, 8'hA0, 8'h00, 1'b0, 1'b0);
        expect_res("R2 high only", 8'h00, 8'h00, 1'b1, 1'b0);
        issue(2'd0, 8'h99, 8'h7E, 1'b0, 1'b0);
        expect_res("R11 ah kept", 8'h99, 8'h7E, 1'b0, 1'b0);
        expect_szp("R4 0x99", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_packed_sticky_r3();
        issue(2'd0, 8'h12, 8'h00, 1'b1, 1'b1);
        expect_res("R3 sticky add", 8'h78, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_packed_sub();
        issue(2'd1, 8'h0F, 8'h00, 1'b0, 1'b0);
        expect_res("R1 sub low", 8'h09, 8'h00, 1'b0, 1'b1);
        issue(2'd1, 8'h00, 8'h00, 1'b1, 1'b1);
        expect_res("R9 sub wrap", 8'h9A, 8'h00, 1'b1, 1'b1);
        expect_szp("R4 0x9A", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_unpacked();
        issue(2'd2, 8'h0B, 8'h03, 1'b0, 1'b0);
        expect_res("R5 up add", 8'h01, 8'h04, 1'b1, 1'b1);
        issue(2'd2, 8'hFA, 8'hFF, 1'b0, 1'b0);
        expect_res("R9 up wrap", 8'h00, 8'h00, 1'b1, 1'b1);
        issue(2'd3, 8'h05, 8'h00, 1'b0, 1'b1);
        expect_res("R5 up sub", 8'h0F, 8'hFF, 1'b1, 1'b1);
        issue(2'd2, 8'h37, 8'h12, 1'b1, 1'b0);
        expect_res("R6 R7 no fix", 8'h07, 8'h12, 1'b0, 1'b0);
    endtask

    task automatic t_keep_szp_r8();
        issue(2'd0, 8'h99, 8'h00, 1'b0, 1'b0);
        expect_szp("R8 setup", 1'b1, 1'b0, 1'b1);
        issue(2'd3, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_szp("R8 kept", 1'b1, 1'b0, 1'b1);
        expect_res("R6 R7 up sub", 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_timing_r10();
        @(negedge clk);
        op_sel = 2'd0; al_in = 8'h3C; ah_in = 8'h11; cf_in = 1'b0; af_in = 1'b0; op_valid = 1'b1;
        chk("R10 not early", al_q, 8'h00);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10 valid", 8'(res_valid), 8'h01);
        chk("R10 loaded", al_q, 8'h42);
        al_in = 8'h0B; ah_in = 8'h55; af_in = 1'b1; cf_in = 1'b1;
        @(negedge clk);
        chk("R10 valid drop", 8'(res_valid), 8'h00);
        expect_res("R10 hold", 8'h42, 8'h11, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r12();
        rst_n = 1'b1;
        t_packed_add();
        t_packed_sticky_r3();
        t_packed_sub();
        t_unpacked();
        t_keep_szp_r8();
        // after the last unpacked op the state is 0; re-seed for timing check
        issue(2'd0, 8'h00, 8'h00, 1'b0, 1'b0);
        t_timing_r10();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule